// File: doc/BRIEF.md
# Manchester Serial Packet Receiver with CRC Check

This block takes a Manchester-encoded serial stream and turns each packet on it into 32-bit words in a receive FIFO. The stream comes from an external line or, when the loopback select is high, from the local transmitter's output. The block samples the line at four times the bit rate. It finds word alignment by matching a fixed 32-bit sync pattern. It then assembles the data words that follow and keeps a running CRC over them. It also recognises the final word of the packet as the CRC and does not store it.

Software arms the receiver for exactly one packet with a one-cycle `arm` pulse. A packet already in progress when the pulse arrives is skipped. After the packet has ended, the status outputs report four things: the receiver is no longer busy, the packet completed, the FIFO overflowed, or the CRC did not match. A one-cycle `flush` pulse cancels any reception, clears all status and empties the FIFO. Words are read back one at a time through the `pop` port.

Top module: `mrx_receiver`

## Requirements
- R1: The line is sampled once per clock, four samples per bit. A 1 bit is two high samples followed by two low samples. A 0 bit is two low samples followed by two high samples. The idle line is high. Bits arrive most significant first.
- R2: Word alignment is found only after the 32 most recent decoded bits equal 0xAAAAAAAB. This sync word is never written to the FIFO.
- R3: Data words are written to the FIFO in arrival order. A pop pulse presents the oldest word on `pop_data` one clock later. The final word of the packet (the CRC) is never written.
- R4: The CRC register starts at all ones and takes each data word most significant bit first, using generator 0x04C11DB7. Its inverted value must equal the final word. On a mismatch, or when a packet ends on a partial word, `crc_err` is set.
- R5: A packet ends when no mid-bit transition has occurred for two bit times. At that point `busy` clears and `pkt_done` sets, unless an overflow has already ended the reception.
- R6: An `arm` pulse sets `busy` and enables the receiver for the next packet only. A packet that arrives while not armed, or after the armed packet has ended, leaves the FIFO and the flags unchanged.
- R7: If `arm` is pulsed while a packet is on the line, that whole packet is ignored and `busy` stays set for the next one.
- R8: If a data word is due to be written while the FIFO holds DEPTH words, the following happens. `ovf_err` sets, `busy` clears, the rest of the packet is ignored, `pkt_done` stays clear, and the stored words are kept.
- R9: At most `max_lines` x 4 data words of one packet are stored. Further data words are dropped, but they still count toward the CRC. With `max_lines` of 0, no word is stored.
- R10: A `flush` pulse aborts any reception. On the next clock it clears `busy`, `pkt_done`, `ovf_err` and `crc_err`, and sets `fifo_count` to 0.
- R11: When `loop_sel` is 1, the receiver decodes `loop_tx` and ignores `line_rx`. When `loop_sel` is 0, it decodes `line_rx` and ignores `loop_tx`.
- R12: After `rst`, `busy`, `pkt_done`, `ovf_err` and `crc_err` are 0 and `fifo_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, four times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| line_rx | input | 1 | External serial line |
| loop_tx | input | 1 | Local transmitter output, used in loopback |
| loop_sel | input | 1 | 1 selects loopback as the serial source |
| arm | input | 1 | One-cycle pulse: receive the next packet |
| flush | input | 1 | One-cycle pulse: abort, clear status, empty FIFO |
| max_lines | input | LEN_W | Buffer limit in 4-word lines |
| pop | input | 1 | Read one word from the FIFO |
| pop_data | output | 32 | Word read by the previous pop |
| fifo_count | output | CNT_W | Words held in the FIFO |
| busy | output | 1 | Receiver armed or receiving |
| pkt_done | output | 1 | Packet completed without overflow |
| ovf_err | output | 1 | FIFO overflow during reception |
| crc_err | output | 1 | CRC mismatch or truncated final word |

## Verification
The hardest state to reach is an `arm` pulse that lands in the middle of a packet. The bench runs the packet sender and a delayed `arm` pulse side by side, so the pulse falls hundreds of samples into a frame. It then checks that nothing was stored and that a following packet is still accepted. Overflow must strike on one exact word, so the bench reduces the FIFO to 15 entries and sends 17 data words. With the one-word hold-back, the sixteenth write is the one that finds the FIFO full. The bench also sweeps packet lengths from 0 to 12 words across several data patterns, and computes every expected CRC on its own.

// File: rtl/mrx_pkg.sv
package mrx_pkg;
  localparam int          WORD_W    = 32;
  localparam logic [31:0] SYNC_WORD = 32'hAAAAAAAB;
  localparam logic [31:0] CRC_GEN   = 32'h04C11DB7;

  typedef enum logic [1:0] {ST_OFF, ST_WAIT, ST_HUNT, ST_DATA} rx_state_t;

  // Fold one word into the CRC, most significant bit first.
  function automatic logic [31:0] crc_fold(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 31; i >= 0; i--) begin
      if (r[31] ^ d[i]) r = {r[30:0], 1'b0} ^ CRC_GEN;
      else              r = {r[30:0], 1'b0};
    end
    return r;
  endfunction
endpackage

// File: rtl/mrx_mdec.sv
module mrx_mdec #(
  parameter int OVS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic line_rx,
  input  logic loop_tx,
  input  logic loop_sel,
  output logic bit_vld,
  output logic bit_val,
  output logic quiet
);
  localparam int QUIET_N = 2 * OVS;
  localparam int MID_MIN = (3 * OVS) / 4;
  localparam int CW      = $clog2(QUIET_N + 1);
  localparam logic [CW-1:0] QUIET_C = CW'(QUIET_N);
  localparam logic [CW-1:0] MID_C   = CW'(MID_MIN);

  logic          s0, s1;
  logic [CW-1:0] gap;
  logic          edge_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      s0  <= 1'b1;
      s1  <= 1'b1;
      gap <= QUIET_C;
    end else begin
      s0 <= loop_sel ? loop_tx : line_rx;
      s1 <= s0;
      if (bit_vld)           gap <= '0;
      else if (gap != QUIET_C) gap <= gap + 1'b1;
    end
  end

  // A transition far enough from the last mid-bit one is the next mid-bit edge;
  // boundary transitions fall half a bit after and are skipped.
  assign edge_seen = s0 ^ s1;
  assign bit_vld   = edge_seen && (gap >= MID_C);
  assign bit_val   = s1;
  assign quiet     = (gap == QUIET_C);

  a_r5_quiet_after_bit: assert property (@(posedge clk) disable iff (rst)
    bit_vld |=> !quiet);
endmodule

// File: rtl/mrx_fifo.sv
module mrx_fifo #(
  parameter int DEPTH = 255,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic            push,
  input  logic [W-1:0]    wdata,
  input  logic            pop,
  output logic [W-1:0]    rdata,
  output logic [CNTW-1:0] count,
  output logic            full
);
  localparam logic [AW-1:0]   LAST   = AW'(DEPTH - 1);
  localparam logic [CNTW-1:0] FULL_C = CNTW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (count == FULL_C);
  assign do_push = push && !full;
  assign do_pop  = pop && (count != '0);

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
    if (do_pop)  rdata   <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      count <= count + CNTW'(do_push) - CNTW'(do_pop);
    end
  end

  a_r8_push_room: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  a_r3_count_step: assert property (@(posedge clk) disable iff (rst)
    (!flush && push && !full && !pop) |=> count == $past(count) + 1'b1);
  a_r10_flush_empty: assert property (@(posedge clk) disable iff (rst)
    flush |=> count == '0);
endmodule

// File: rtl/mrx_ctrl.sv
module mrx_ctrl
  import mrx_pkg::*;
#(
  parameter int LEN_W = 20,
  parameter int LW    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             flush,
  input  logic [LEN_W-1:0] max_lines,
  input  logic             bit_vld,
  input  logic             bit_val,
  input  logic             quiet,
  input  logic             fifo_full,
  output logic             push,
  output logic [31:0]      push_data,
  output logic             busy,
  output logic             done,
  output logic             ovf,
  output logic             crc_err
);
  localparam int SW = LEN_W + LW;

  rx_state_t   state;
  logic [31:0] sh, held, crc;
  logic [31:0] sh_next;
  logic        have_w;
  logic [4:0]  bcnt;
  logic [SW-1:0] stored, limit;
  logic        word_ev, room;

  assign sh_next   = {sh[30:0], bit_val};
  assign limit     = {max_lines, {LW{1'b0}}};
  assign room      = (stored < limit);
  assign word_ev   = (state == ST_DATA) && bit_vld && (bcnt == 5'd31);
  assign push      = word_ev && have_w && room && !fifo_full;
  assign push_data = held;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      state   <= ST_OFF;
      busy    <= 1'b0;
      done    <= 1'b0;
      ovf     <= 1'b0;
      crc_err <= 1'b0;
      sh      <= '0;
      held    <= '0;
      crc     <= '1;
      have_w  <= 1'b0;
      bcnt    <= '0;
      stored  <= '0;
    end else if (arm) begin
      state <= ST_WAIT;
      busy  <= 1'b1;
    end else begin
      case (state)
        ST_WAIT: if (quiet) begin
          state <= ST_HUNT;
          sh    <= '0;
        end
        ST_HUNT: begin
          if (bit_vld) begin
            sh <= sh_next;
            if (sh_next == SYNC_WORD) begin
              state  <= ST_DATA;
              bcnt   <= '0;
              have_w <= 1'b0;
              crc    <= '1;
              stored <= '0;
            end
          end else if (quiet) begin
            sh <= '0;
          end
        end
        ST_DATA: begin
          if (bit_vld) begin
            sh   <= sh_next;
            bcnt <= bcnt + 1'b1;
            if (bcnt == 5'd31) begin
              held   <= sh_next;
              have_w <= 1'b1;
              if (have_w) begin
                crc <= crc_fold(crc, held);
                if (room) begin
                  if (fifo_full) begin
                    ovf   <= 1'b1;
                    busy  <= 1'b0;
                    state <= ST_OFF;
                  end else begin
                    stored <= stored + 1'b1;
                  end
                end
              end
            end
          end else if (quiet) begin
            state   <= ST_OFF;
            busy    <= 1'b0;
            done    <= 1'b1;
            crc_err <= !(have_w && (bcnt == 5'd0) && (~crc == held));
          end
        end
        default: ;
      endcase
    end
  end

  a_r5_end_reports: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(flush)) |-> (done || ovf));
  a_r8_ovf_stops: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> !busy);
  a_r6_data_needs_arm: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DATA) |-> busy);
endmodule

// File: rtl/mrx_receiver.sv
module mrx_receiver #(
  parameter int  DEPTH = 255,
  parameter int  LEN_W = 20,
  parameter int  OVS   = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_rx,
  input  logic             loop_tx,
  input  logic             loop_sel,
  input  logic             arm,
  input  logic             flush,
  input  logic [LEN_W-1:0] max_lines,
  input  logic             pop,
  output logic [31:0]      pop_data,
  output logic [CNT_W-1:0] fifo_count,
  output logic             busy,
  output logic             pkt_done,
  output logic             ovf_err,
  output logic             crc_err
);
  logic        bit_vld, bit_val, quiet;
  logic        push, full;
  logic [31:0] push_data;

  mrx_mdec #(.OVS(OVS)) u_dec (
    .clk(clk), .rst(rst), .line_rx(line_rx), .loop_tx(loop_tx),
    .loop_sel(loop_sel), .bit_vld(bit_vld), .bit_val(bit_val), .quiet(quiet)
  );

  mrx_ctrl #(.LEN_W(LEN_W), .LW(2)) u_ctrl (
    .clk(clk), .rst(rst), .arm(arm), .flush(flush), .max_lines(max_lines),
    .bit_vld(bit_vld), .bit_val(bit_val), .quiet(quiet), .fifo_full(full),
    .push(push), .push_data(push_data), .busy(busy), .done(pkt_done),
    .ovf(ovf_err), .crc_err(crc_err)
  );

  mrx_fifo #(.DEPTH(DEPTH), .W(32)) u_fifo (
    .clk(clk), .rst(rst), .flush(flush), .push(push), .wdata(push_data),
    .pop(pop), .rdata(pop_data), .count(fifo_count), .full(full)
  );

  a_r10_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!busy && !pkt_done && !ovf_err && !crc_err && fifo_count == '0));
  a_r12_idle_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !pkt_done && !ovf_err && !crc_err));
endmodule

// File: tb/sim_mrx_receiver.sv
module sim_mrx_receiver;
  localparam int DEPTH = 15;
  localparam int LEN_W = 20;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_rx = 1'b1, loop_tx = 1'b1, loop_sel = 1'b0;
  logic arm = 1'b0, flush = 1'b0, pop = 1'b0;
  logic [LEN_W-1:0] max_lines = '1;
  logic [31:0] pop_data;
  logic [CNT_W-1:0] fifo_count;
  logic busy, pkt_done, ovf_err, crc_err;

  int vec = 0, bad = 0;
  bit use_loop = 1'b0;
  bit ended = 1'b0;

  always #5 clk = ~clk;

  mrx_receiver #(.DEPTH(DEPTH), .LEN_W(LEN_W), .OVS(4)) u0 (
    .clk(clk), .rst(rst), .line_rx(line_rx), .loop_tx(loop_tx), .loop_sel(loop_sel),
    .arm(arm), .flush(flush), .max_lines(max_lines), .pop(pop), .pop_data(pop_data),
    .fifo_count(fifo_count), .busy(busy), .pkt_done(pkt_done), .ovf_err(ovf_err),
    .crc_err(crc_err)
  );

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    logic top;
    r = c;
    for (int j = 31; j >= 0; j--) begin
      top = r[31] ^ d[j];
      r = r << 1;
      if (top) r = r ^ 32'h04C11DB7;
    end
    return r;
  endfunction

  function automatic logic [31:0] dw(input int i, input int s);
    case (s)
      0:       return (i % 2 == 0) ? 32'h0 : 32'hFFFFFFFF;
      1:       return 32'h12345678 + 32'(i) * 32'h11111111;
      2:       return {16'(i), 16'hA5C3} ^ 32'h5A000000;
      default: return 32'(i * 7919 + 13) * 32'h9E3779B1;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic v);
    @(negedge clk);
    if (use_loop) loop_tx = v; else line_rx = v;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) put(1'b1);
  endtask

  task automatic send_word(input logic [31:0] w);
    for (int b = 31; b >= 0; b--) begin
      put(w[b]); put(w[b]); put(~w[b]); put(~w[b]);
    end
  endtask

  task automatic send_pkt(input int n, input int s, input bit bad_crc);
    logic [31:0] c;
    c = '1;
    for (int i = 0; i < n; i++) c = ref_crc(c, dw(i, s));
    send_word(32'hAAAAAAAB);
    for (int i = 0; i < n; i++) send_word(dw(i, s));
    send_word(~c ^ {31'b0, bad_crc});
    idle(40);
  endtask

  task automatic arm_p();
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
  endtask

  task automatic flush_p();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  task automatic pop_chk(input string tag, input int n, input int s);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); pop = 1'b1;
      @(negedge clk); pop = 1'b0;
      chk(tag, pop_data, dw(i, s));
    end
  endtask

  task automatic status_chk(input string tag, input int cnt, input bit b,
                            input bit d, input bit o, input bit c);
    @(negedge clk);
    chk({tag, " count"}, 32'(fifo_count), 32'(cnt));
    chk({tag, " busy"}, 32'(busy), 32'(b));
    chk({tag, " done"}, 32'(pkt_done), 32'(d));
    chk({tag, " ovf"}, 32'(ovf_err), 32'(o));
    chk({tag, " crc"}, 32'(crc_err), 32'(c));
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    vec++; bad++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    finish_up();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R12 state after reset
    status_chk("R12 reset", 0, 0, 0, 0, 0);

    // R1 R2 R3 R4 R5: length sweep over several data patterns
    for (int n = 0; n <= 12; n++) begin
      flush_p();
      arm_p();
      send_pkt(n, n % 4, 1'b0);
      status_chk("R5 R4 sweep", n, 0, 1, 0, 0);
      pop_chk("R1 R3 sweep data", n, n % 4);
    end

    // R4 corrupted CRC word
    flush_p(); arm_p();
    send_pkt(3, 2, 1'b1);
    status_chk("R4 bad crc", 3, 0, 1, 0, 1);
    // R10 flush clears sticky flags
    flush_p();
    status_chk("R10 flush flags", 0, 0, 0, 0, 0);

    // R6 one packet per arm, and nothing when not armed
    arm_p();
    send_pkt(2, 1, 1'b0);
    send_pkt(3, 3, 1'b0);
    status_chk("R6 single packet", 2, 0, 1, 0, 0);
    pop_chk("R6 first packet data", 2, 1);
    flush_p();
    send_pkt(2, 2, 1'b0);
    status_chk("R6 not armed", 0, 0, 0, 0, 0);

    // R7 arm lands inside a packet
    flush_p();
    fork
      send_pkt(5, 1, 1'b0);
      begin repeat (400) @(negedge clk); arm_p(); end
    join
    status_chk("R7 mid-packet arm", 0, 1, 0, 0, 0);
    send_pkt(2, 3, 1'b0);
    status_chk("R7 next packet", 2, 0, 1, 0, 0);
    pop_chk("R7 next data", 2, 3);

    // R8 overflow on the sixteenth write
    flush_p(); arm_p();
    send_pkt(17, 2, 1'b0);
    status_chk("R8 overflow", DEPTH, 0, 0, 1, 0);
    pop_chk("R8 kept data", DEPTH, 2);

    // R9 buffer limit in lines
    flush_p(); max_lines = 20'd1; arm_p();
    send_pkt(6, 3, 1'b0);
    status_chk("R9 limit one line", 4, 0, 1, 0, 0);
    pop_chk("R9 limited data", 4, 3);
    flush_p(); max_lines = 20'd0; arm_p();
    send_pkt(3, 1, 1'b0);
    status_chk("R9 limit zero", 0, 0, 1, 0, 0);
    max_lines = '1;

    // R11 loopback source select
    flush_p(); loop_sel = 1'b1; use_loop = 1'b1; arm_p();
    send_pkt(4, 1, 1'b0);
    status_chk("R11 loopback", 4, 0, 1, 0, 0);
    pop_chk("R11 loopback data", 4, 1);
    flush_p(); loop_sel = 1'b0; arm_p();
    send_pkt(3, 2, 1'b0);
    status_chk("R11 loop ignored", 0, 1, 0, 0, 0);
    use_loop = 1'b0;

    // R10 abort mid-packet
    flush_p(); arm_p();
    fork
      send_pkt(6, 0, 1'b0);
      begin repeat (500) @(negedge clk); flush_p(); end
    join
    status_chk("R10 abort", 0, 0, 0, 0, 0);

    finish_up();
  end
endmodule